// File: doc/BRIEF.md
# LCD Raster Sync Timing Generator

This block produces the raster timing an RGB LCD panel needs: a horizontal sync pulse, a vertical sync pulse, a data-enable strobe and a pixel clock. Two counter stages each walk four phases in a fixed order: sync, back porch, active and front porch. The horizontal stage advances once per pixel period. The vertical stage advances once per completed line. Eight write-only configuration fields set the length of every phase. One control field sets the output polarities and the pixel-clock edge on which the panel samples.

Live status comes out on ports: the current horizontal and vertical phase codes, and a line counter that numbers the lines of the active region. Host logic uses these to pace pixel fetch. Fetch, palette lookup and data reordering belong to neighbouring blocks.

Top module: `lcd_raster_timer`

## Requirements
- R1: While reset is asserted and in the cycle it is released, every configuration field is zero, `pclk_o` is 0, both status codes are 00, `line_o` is 0, `hsync_o` and `vsync_o` are 1, and `de_o` is 0.
- R2: `pclk_o` toggles on every `clk` cycle, so one pixel period is two cycles. The timing state changes only at a `clk` edge where `pclk_o` leaves the level equal to the edge bit (control bit 3). So with edge bit 1 (panel samples on the rising edge) the outputs change together with the falling edge of `pclk_o`, and with edge bit 0 they change with its rising edge.
- R3: The horizontal phase cycles sync, back porch, active, front porch. Each phase lasts exactly its configured length in pixel periods. `h_status_o` reads 00 for sync, 01 for back porch, 10 for active and 11 for front porch.
- R4: The vertical phase advances only at the pixel step that ends a horizontal front porch. It cycles through the same four phases, each lasting its configured number of lines. `v_status_o` uses the same encoding as R3.
- R5: `line_o` becomes 0 on the first line of the vertical active region and increases by 1 on each later line of that region. Outside the region it holds its value.
- R6: `de_o` is 1 exactly when both phases are active, and it is inverted when control bit 2 is 1.
- R7: `hsync_o` is 1 during the horizontal sync phase and 0 otherwise, and is inverted when control bit 0 is 1. `vsync_o` behaves the same way for the vertical sync phase, with control bit 1 as its inversion bit.
- R8: A write with `cfg_we` high loads one register at the next edge. Address 0 is control: bit 0 inverts hsync, bit 1 inverts vsync, bit 2 inverts data enable, bit 3 is the edge bit. Addresses 1 and 3 hold the sync length in bits [10:0] and the back-porch length in bits [26:16], for horizontal and vertical timing respectively. Addresses 2 and 4 hold the active length in bits [10:0] and the front-porch length in bits [26:16], again for horizontal and vertical timing.
- R9: A configured length of 0 gives a phase that lasts one period, the same as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pclk_o | output | 1 | Pixel clock to the panel |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| h_status_o | output | 2 | Horizontal phase code |
| v_status_o | output | 2 | Vertical phase code |
| line_o | output | CNT_W (11) | Active-region line number |

## Verification
The end of a horizontal line coincides with a vertical phase change in the same cycle. When that vertical change is the entry to the active region, the line counter restarts in that cycle as well. Short phase lengths, including zero lengths, make these coincidences happen every few dozen cycles. A per-cycle reference model, built from the phase thresholds and not from counters, predicts both status codes, the line number and all polarised outputs for every cycle. A change of the edge bit or a polarity bit is also written in the middle of a frame, so that its effect lands in the same cycle as a pixel step.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'b00,
        PH_BACK  = 2'b01,
        PH_ACT   = 2'b10,
        PH_FRONT = 2'b11
    } phase_e;

    localparam int unsigned REG_ADDR_W = 3;
    localparam int unsigned REG_DATA_W = 32;
    localparam int unsigned HI_LSB     = REG_DATA_W / 2;

    localparam logic [REG_ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_HSB   = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_HAF   = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_VSB   = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_VAF   = 3'd4;

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
    import lcd_raster_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [REG_DATA_W-1:0] wdata_i,
    output logic                  inv_h_o,
    output logic                  inv_v_o,
    output logic                  inv_de_o,
    output logic                  edge_o,
    output logic [CNT_W-1:0]      h_len_o [4],
    output logic [CNT_W-1:0]      v_len_o [4]
);

    typedef struct packed {
        logic [3:0]       ctrl;
        logic [CNT_W-1:0] hs, hb, ha, hf;
        logic [CNT_W-1:0] vs, vb, va, vf;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    logic [CNT_W-1:0] lo_fld, hi_fld;
    logic             unused_wdata;

    assign lo_fld       = wdata_i[CNT_W-1:0];
    assign hi_fld       = wdata_i[HI_LSB+CNT_W-1:HI_LSB];
    assign unused_wdata = ^wdata_i;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            unique case (addr_i)
                A_CTRL:  cfg_d.ctrl = wdata_i[3:0];
                A_HSB:   begin cfg_d.hs = lo_fld; cfg_d.hb = hi_fld; end
                A_HAF:   begin cfg_d.ha = lo_fld; cfg_d.hf = hi_fld; end
                A_VSB:   begin cfg_d.vs = lo_fld; cfg_d.vb = hi_fld; end
                A_VAF:   begin cfg_d.va = lo_fld; cfg_d.vf = hi_fld; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign inv_h_o  = cfg_q.ctrl[0];
    assign inv_v_o  = cfg_q.ctrl[1];
    assign inv_de_o = cfg_q.ctrl[2];
    assign edge_o   = cfg_q.ctrl[3];

    assign h_len_o[0] = cfg_q.hs;
    assign h_len_o[1] = cfg_q.hb;
    assign h_len_o[2] = cfg_q.ha;
    assign h_len_o[3] = cfg_q.hf;
    assign v_len_o[0] = cfg_q.vs;
    assign v_len_o[1] = cfg_q.vb;
    assign v_len_o[2] = cfg_q.va;
    assign v_len_o[3] = cfg_q.vf;

    // R8: a register keeps its contents when no write strobe is present
    assert_hold_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_q));

endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_raster_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [CNT_W-1:0] len_i [4],
    output phase_e           phase_o,
    output logic             last_o,
    output logic             wrap_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_s;

    seq_s             s_d, s_q;
    logic [CNT_W-1:0] cur_len;
    logic             last;

    always_comb begin
        cur_len = len_i[s_q.phase];
        last    = (cur_len == '0) || (s_q.cnt >= cur_len - CNT_W'(1));
        s_d     = s_q;
        if (step_i) begin
            if (last) begin
                s_d.phase = phase_e'(2'(s_q.phase + 2'd1));
                s_d.cnt   = '0;
            end else begin
                s_d.cnt   = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_SYNC, cnt: '0};
        else        s_q <= s_d;
    end

    assign phase_o = s_q.phase;
    assign last_o  = last;
    assign wrap_o  = step_i && last && (s_q.phase == PH_FRONT);

    // R3: phase and count are frozen between steps
    assert_freeze_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(s_q.phase) && $stable(s_q.cnt)));

    // R3: a step either keeps the phase or moves to the next one in order
    assert_phase_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (s_q.phase == $past(s_q.phase)
                    || s_q.phase == phase_e'(2'($past(s_q.phase) + 2'd1))));

endmodule

// File: rtl/lcd_pol_out.sv
module lcd_pol_out
    import lcd_raster_pkg::*;
(
    input  phase_e h_phase_i,
    input  phase_e v_phase_i,
    input  logic   inv_h_i,
    input  logic   inv_v_i,
    input  logic   inv_de_i,
    output logic   hsync_o,
    output logic   vsync_o,
    output logic   de_o
);

    always_comb begin
        hsync_o = (h_phase_i == PH_SYNC) ^ inv_h_i;
        vsync_o = (v_phase_i == PH_SYNC) ^ inv_v_i;
        de_o    = ((h_phase_i == PH_ACT) && (v_phase_i == PH_ACT)) ^ inv_de_i;
    end

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcd_raster_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic             pclk_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [1:0]       h_status_o,
    output logic [1:0]       v_status_o,
    output logic [CNT_W-1:0] line_o
);

    typedef struct packed {
        logic             pclk;
        logic [CNT_W-1:0] line;
    } top_s;

    top_s top_d, top_q;

    logic             inv_h, inv_v, inv_de, edge_sel;
    logic [CNT_W-1:0] h_len [4];
    logic [CNT_W-1:0] v_len [4];
    phase_e           h_phase, v_phase;
    logic             h_step, h_last, h_wrap;
    logic             v_last, v_wrap_unused;

    lcd_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .addr_i   (cfg_addr),
        .wdata_i  (cfg_wdata),
        .inv_h_o  (inv_h),
        .inv_v_o  (inv_v),
        .inv_de_o (inv_de),
        .edge_o   (edge_sel),
        .h_len_o  (h_len),
        .v_len_o  (v_len)
    );

    assign h_step = (top_q.pclk == edge_sel);

    lcd_phase_seq #(.CNT_W(CNT_W)) u_hseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (h_step),
        .len_i   (h_len),
        .phase_o (h_phase),
        .last_o  (h_last),
        .wrap_o  (h_wrap)
    );

    lcd_phase_seq #(.CNT_W(CNT_W)) u_vseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (h_wrap),
        .len_i   (v_len),
        .phase_o (v_phase),
        .last_o  (v_last),
        .wrap_o  (v_wrap_unused)
    );

    always_comb begin
        top_d      = top_q;
        top_d.pclk = ~top_q.pclk;
        if (h_wrap) begin
            if (v_phase == PH_BACK && v_last)
                top_d.line = '0;
            else if (v_phase == PH_ACT && !v_last)
                top_d.line = top_q.line + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    lcd_pol_out u_out (
        .h_phase_i (h_phase),
        .v_phase_i (v_phase),
        .inv_h_i   (inv_h),
        .inv_v_i   (inv_v),
        .inv_de_i  (inv_de),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o),
        .de_o      (de_o)
    );

    assign pclk_o     = top_q.pclk;
    assign h_status_o = h_phase;
    assign v_status_o = v_phase;
    assign line_o     = top_q.line;

    // R2: horizontal timing moves only at the selected pixel-clock edge
    assert_h_edge_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.pclk != edge_sel) |=> $stable(h_phase));

    // R4: vertical phase changes only when a line ends
    assert_v_at_line_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_phase != PH_FRONT) |=> $stable(v_phase));

    // R5: line number is held through vertical sync and front porch
    assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_phase == PH_SYNC || v_phase == PH_FRONT) |=> $stable(top_q.line));

endmodule

// File: tb/lcd_raster_timer_test.sv
module lcd_raster_timer_test;

    localparam int CNT_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             pclk_o, hsync_o, vsync_o, de_o;
    logic [1:0]       h_status_o, v_status_o;
    logic [CNT_W-1:0] line_o;

    always #2 clk = ~clk;

    lcd_raster_timer #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pclk_o(pclk_o), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .h_status_o(h_status_o),
        .v_status_o(v_status_o), .line_o(line_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // shadow of the register contents, per R8
    logic [3:0] sh_ctrl = '0;
    int         sh_len [8];  // hs hb ha hf vs vb va vf

    // reference model: absolute positions within line and frame
    bit model_on = 0;
    bit arm      = 0;
    int mh, mv, mline;
    bit mpclk;

    typedef struct packed {
        logic        pclk, hs, vs, de;
        logic [1:0]  hst, vst;
        logic [15:0] line;
    } exp_s;
    exp_s q[$];

    function automatic int eff(input int n);
        return (n == 0) ? 1 : n;  // R9
    endfunction

    function automatic int phase_at(input int pos, input int s, input int b, input int a);
        if (pos < eff(s)) return 0;
        if (pos < eff(s) + eff(b)) return 1;
        if (pos < eff(s) + eff(b) + eff(a)) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            if (model_on) begin
                int htot, vtot, hp, vp;
                bit step;
                exp_s e;
                htot = eff(sh_len[0]) + eff(sh_len[1]) + eff(sh_len[2]) + eff(sh_len[3]);
                vtot = eff(sh_len[4]) + eff(sh_len[5]) + eff(sh_len[6]) + eff(sh_len[7]);
                step  = (mpclk == sh_ctrl[3]);
                mpclk = ~mpclk;
                if (step) begin
                    mh++;
                    if (mh == htot) begin
                        mh = 0;
                        mv++;
                        if (mv == vtot) mv = 0;
                        if (phase_at(mv, sh_len[4], sh_len[5], sh_len[6]) == 2)
                            mline = mv - eff(sh_len[4]) - eff(sh_len[5]);
                    end
                end
                if (cfg_we && cfg_addr == 3'd0) sh_ctrl = cfg_wdata[3:0];
                hp = phase_at(mh, sh_len[0], sh_len[1], sh_len[2]);
                vp = phase_at(mv, sh_len[4], sh_len[5], sh_len[6]);
                e.pclk = mpclk;
                e.hs   = (hp == 0) ^ sh_ctrl[0];
                e.vs   = (vp == 0) ^ sh_ctrl[1];
                e.de   = (hp == 2 && vp == 2) ^ sh_ctrl[2];
                e.hst  = 2'(hp);
                e.vst  = 2'(vp);
                e.line = 16'(mline);
                q.push_back(e);
            end else if (cfg_we) begin
                case (cfg_addr)
                    3'd0: sh_ctrl = cfg_wdata[3:0];
                    3'd1: begin sh_len[0] = int'(cfg_wdata[10:0]); sh_len[1] = int'(cfg_wdata[26:16]); end
                    3'd2: begin sh_len[2] = int'(cfg_wdata[10:0]); sh_len[3] = int'(cfg_wdata[26:16]); end
                    3'd3: begin sh_len[4] = int'(cfg_wdata[10:0]); sh_len[5] = int'(cfg_wdata[26:16]); end
                    3'd4: begin sh_len[6] = int'(cfg_wdata[10:0]); sh_len[7] = int'(cfg_wdata[26:16]); end
                    default: ;
                endcase
            end
        end
    end

    // monitor: pop expected item, compare; then detect frame start for resync
    logic [1:0] prev_vst = 2'b00;
    always @(negedge clk) begin
        if (model_on && q.size() > 0) begin
            exp_s e;
            e = q.pop_front();
            chk("R2 pclk",     int'(pclk_o),     int'(e.pclk));
            chk("R3 h_status", int'(h_status_o), int'(e.hst));
            chk("R4 v_status", int'(v_status_o), int'(e.vst));
            chk("R5 line",     int'(line_o),     int'(e.line));
            chk("R6 de",       int'(de_o),       int'(e.de));
            chk("R7 hsync",    int'(hsync_o),    int'(e.hs));
            chk("R7 vsync",    int'(vsync_o),    int'(e.vs));
        end
        if (arm && rst_n && prev_vst == 2'b11 && v_status_o == 2'b00) begin
            mh = 0; mv = 0; mpclk = pclk_o; mline = int'(line_o);
            arm = 0; model_on = 1;
        end
        prev_vst = v_status_o;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic timing(input int hs, hb, ha, hf, vs, vb, va, vf);
        model_on = 0;
        q.delete();
        wr(3'd1, {16'(hb), 16'(hs)});
        wr(3'd2, {16'(hf), 16'(ha)});
        wr(3'd3, {16'(vb), 16'(vs)});
        wr(3'd4, {16'(vf), 16'(va)});
        arm = 1;
        for (int i = 0; i < 5000 && !model_on; i++) @(negedge clk);
        chk("R4 frame start seen", int'(model_on), 1);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) sh_len[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pclk",  int'(pclk_o), 0);
        chk("R1 hstat", int'(h_status_o), 0);
        chk("R1 vstat", int'(v_status_o), 0);
        chk("R1 line",  int'(line_o), 0);
        chk("R1 hsync", int'(hsync_o), 1);
        chk("R1 vsync", int'(vsync_o), 1);
        chk("R1 de",    int'(de_o), 0);
        rst_n = 1'b1;
        // R9: all-zero lengths behave as length one
        arm = 1;
        for (int i = 0; i < 200 && !model_on; i++) @(negedge clk);
        chk("R9 frame start seen", int'(model_on), 1);
        run(120);
        // R3 R4 R5 R8: regular timing
        timing(2, 3, 4, 1, 1, 2, 3, 2);
        run(400);
        // R6 R7: all inversions on, written mid-frame
        wr(3'd0, 32'h0000_0007);
        run(300);
        // R2: panel samples on rising edge
        wr(3'd0, 32'h0000_0008);
        run(400);
        wr(3'd0, 32'h0000_000D);
        run(200);
        // R9: zero lengths mixed with non-zero
        timing(1, 0, 3, 0, 2, 0, 2, 1);
        run(400);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule